// File: doc/BRIEF.md
# Return-Address Stack Controller with Status Save

This block manages an eight-deep stack of return addresses that lives inside a small data RAM rather than in dedicated flip-flops. When a subroutine call or an interrupt is taken, the core hands the block its 12-bit program counter and the upper nibble of its status word. The block stores them as one entry made of two RAM bytes and then advances a 3-bit stack pointer. That pointer sits in the low three bits of the status word.

On return, the core picks one of two requests. A plain return gives back only the saved program counter. A status-restoring return also hands back the saved status nibble, marked by a one-cycle valid flag. The stack window covers RAM locations 8 to 23. Entry k uses the byte pair 8+2k and 9+2k, with the low-order program-counter byte at the lower address. The RAM and the interrupt arbitration stay outside the block.

Each operation takes two RAM cycles, one byte per cycle, and ends with a one-cycle completion pulse. The pointer wraps modulo eight and has no overflow or underflow detection. The program counter that is currently running is never held in the stack.

Top module: `ret_stack_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all of the following are 0: `sp`, `busy`, `done`, `rest_valid`, `ram_we`, `ram_re`, `pop_pc` and `rest_stat`.
- R2: A push writes two bytes, both with `ram_we`=1.
  - In its first cycle it writes PC[7:0] to address 8+2*sp.
  - In its second cycle it writes {status[3:0], PC[11:8]} to address 9+2*sp, with the status nibble in bits 7:4 and PC[11:8] in bits 3:0.
- R3: A push increments `sp` by one, modulo 8. The new value is visible in the same cycle as `done`.
- R4: A pop of either kind decrements `sp` by one, modulo 8, on the edge that accepts it, before any RAM access. It then reads address 8+2*sp in its first cycle and 9+2*sp in its second cycle, with `ram_re`=1 and `ram_we`=0. When `done` rises, `pop_pc` equals the saved 12-bit PC of that entry.
- R5: A status-restoring pop drives `rest_stat` to bits 7:4 of the entry's second byte and raises `rest_valid` only in the `done` cycle. A plain pop leaves `rest_stat` unchanged and keeps `rest_valid` at 0.
- R6: An accepted request holds `busy`=1 for exactly two cycles. `done` then pulses for exactly one cycle, in the cycle after the second RAM access.
- R7: Requests that arrive while `busy`=1 are ignored: they start no RAM access, change no pointer and produce no `done`.
- R8: When several requests arrive together, the priority is push, then status-restoring pop, then plain pop.
- R9: A ninth push without an intervening pop overwrites entry 0 at addresses 8 and 9. A pop at `sp`=0 reads entry 7.
- R10: Whenever `ram_we` or `ram_re` is 1, `ram_addr` lies between 8 and 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Save `push_pc` and `push_stat` as a new entry |
| pop_req | input | 1 | Return that restores the PC only |
| popr_req | input | 1 | Return that restores the PC and the status nibble |
| push_pc | input | 12 | Program counter to save |
| push_stat | input | 4 | Status bits 7:4 to save |
| busy | output | 1 | An operation is in its two RAM cycles |
| done | output | 1 | One-cycle completion pulse |
| pop_pc | output | 12 | Program counter taken from the last pop |
| rest_stat | output | 4 | Status nibble taken from the last restoring pop |
| rest_valid | output | 1 | `rest_stat` was refreshed this cycle |
| sp | output | 3 | Stack pointer (status word bits 2:0) |
| ram_addr | output | 8 | RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, valid in the same cycle as the address |

## Verification
The bench builds the block with its default parameters: a 12-bit PC, a 4-bit status nibble, eight levels and a window base of 8. With these values a run of nine pushes, or a pop at pointer 0, reaches both wrap edges of the pointer. Every byte address the window can produce is also reached. The random mix of the three request types, including simultaneous ones and requests raised while busy, exercises the two restore paths against each other, as well as the priority order and the rule that busy requests are ignored.

// File: rtl/rsc_pkg.sv
// Package: shared types for the return stack controller.
// Assumes: one operation in flight at a time.
package rsc_pkg;
    // Sequencer phase: idle, low-byte cycle, high-byte cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } phase_t;

    // Operation kind latched at acceptance.
    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_POPR = 2'd2
    } op_t;
endpackage

// File: rtl/rsc_seq.sv
// Module: rsc_seq
// Accepts one request while idle and steps through two RAM phases, then
// pulses done. The priority among requests is push, restoring pop, plain pop.
// Assumes: requests are level-sampled at the clock edge; busy ones are dropped.
module rsc_seq
    import rsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_req,
    input  logic   pop_req,
    input  logic   popr_req,
    output logic   start,
    output op_t    op_sel,
    output op_t    op_q,
    output phase_t phase,
    output logic   done,
    output logic   busy
);
    logic any_req;

    // Priority select of the incoming request.
    always_comb begin
        any_req = push_req | pop_req | popr_req;
        if (push_req)      op_sel = OP_PUSH;
        else if (popr_req) op_sel = OP_POPR;
        else               op_sel = OP_POP;
        start = (phase == PH_IDLE) && any_req;
        busy  = (phase != PH_IDLE);
    end

    // Phase register and latched operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            op_q  <= OP_PUSH;
        end else begin
            case (phase)
                PH_IDLE: if (any_req) begin
                    phase <= PH_LO;
                    op_q  <= op_sel;
                end
                PH_LO:   phase <= PH_HI;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Completion pulse after the high-byte cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (phase == PH_HI);
    end

    p_lo_then_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LO) |=> (phase == PH_HI));
    p_hi_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HI) |=> (phase == PH_IDLE && done));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LO) |=> $stable(op_q));
endmodule

// File: rtl/rsc_ptr.sv
// Module: rsc_ptr
// Holds the stack pointer. It decrements when a pop is accepted and
// increments when a push finishes. It wraps modulo the depth and does not
// flag overflow or underflow.
// Assumes: inc and dec are never both set in one cycle.
module rsc_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [PTR_W-1:0] sp
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    // Pointer update with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= '0;
        else if (inc) sp <= sp + ONE;
        else if (dec) sp <= sp - ONE;
    end

    p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (sp == PTR_W'($past(sp) + ONE)));
    p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (sp == PTR_W'($past(sp) - ONE)));
    p_one_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));
endmodule

// File: rtl/rsc_addr.sv
// Module: rsc_addr
// Latches the push payload on acceptance and forms the RAM address,
// strobes and write byte for each of the two phases of an entry.
// Assumes: the entry's second byte holds the status nibble above PC[11:8].
module rsc_addr
    import rsc_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int ST_W   = 4,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8,
    parameter int PTR_W  = 3,
    parameter int BASE   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PC_W-1:0]   push_pc,
    input  logic [ST_W-1:0]   push_stat,
    input  phase_t            phase,
    input  op_t               op_q,
    input  logic [PTR_W-1:0]  sp,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [BYTE_W-1:0] ram_wdata
);
    localparam int HI_PC_W = PC_W - BYTE_W;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam int DEPTH = 1 << PTR_W;
    localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(BASE + 2 * DEPTH - 1);

    logic [PC_W-1:0] pc_q;
    logic [ST_W-1:0] st_q;
    logic            hi;
    logic            active;

    // Capture the push payload at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            st_q <= '0;
        end else if (start) begin
            pc_q <= push_pc;
            st_q <= push_stat;
        end
    end

    // Address, strobes and write data for the current phase.
    always_comb begin
        hi        = (phase == PH_HI);
        active    = (phase != PH_IDLE);
        ram_addr  = BASE_A + ADDR_W'({sp, 1'b0}) + ADDR_W'(hi);
        ram_we    = active && (op_q == OP_PUSH);
        ram_re    = active && (op_q != OP_PUSH);
        ram_wdata = hi ? {st_q, pc_q[PC_W-1 -: HI_PC_W]} : pc_q[BYTE_W-1:0];
    end

    p_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_addr >= BASE_A && ram_addr <= TOP_A));
    p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));
    p_pair_adjacent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LO) |=> (ram_addr == $past(ram_addr) + ADDR_W'(1)));
endmodule

// File: rtl/rsc_unpack.sv
// Module: rsc_unpack
// Collects the two bytes read during a pop and rebuilds the PC. For a
// restoring pop it also refreshes the status nibble and pulses the valid flag.
// Assumes: the read byte is valid in the same cycle as the address.
module rsc_unpack
    import rsc_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int ST_W   = 4,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  op_t               op_q,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic [PC_W-1:0]   pop_pc,
    output logic [ST_W-1:0]   rest_stat,
    output logic              rest_valid
);
    localparam int HI_PC_W = PC_W - BYTE_W;

    logic [BYTE_W-1:0] lo_q;
    logic              is_pop;

    // Flag that the active operation is a pop of either kind.
    always_comb is_pop = (op_q != OP_PUSH);

    // Hold the low byte from the first read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                           lo_q <= '0;
        else if (phase == PH_LO && is_pop)    lo_q <= ram_rdata;
    end

    // Rebuild the PC and the restored status on the high-byte cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_pc     <= '0;
            rest_stat  <= '0;
            rest_valid <= 1'b0;
        end else begin
            rest_valid <= 1'b0;
            if (phase == PH_HI && is_pop) begin
                pop_pc <= {ram_rdata[HI_PC_W-1:0], lo_q};
                if (op_q == OP_POPR) begin
                    rest_stat  <= ram_rdata[BYTE_W-1 -: ST_W];
                    rest_valid <= 1'b1;
                end
            end
        end
    end

    p_plain_keeps_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HI && op_q == OP_POP) |=> ($stable(rest_stat) && !rest_valid));
    p_push_keeps_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && op_q == OP_PUSH) |=> $stable(pop_pc));
endmodule

// File: rtl/ret_stack_ctrl.sv
// Module: ret_stack_ctrl (top)
// An eight-level return stack kept in a window of data RAM. Each entry
// takes two bytes: the low PC byte first, then the status nibble above
// PC[11:8]. The pointer forms the low bits of the status word.
// Assumes: an external RAM with combinational read and a write on the clock edge.
module ret_stack_ctrl
    import rsc_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int ST_W   = 4,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 8,
    parameter int BASE   = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              popr_req,
    input  logic [PC_W-1:0]   push_pc,
    input  logic [ST_W-1:0]   push_stat,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   pop_pc,
    output logic [ST_W-1:0]   rest_stat,
    output logic              rest_valid,
    output logic [PTR_W-1:0]  sp,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata
);
    logic   start;
    op_t    op_sel;
    op_t    op_q;
    phase_t phase;
    logic   ptr_inc;
    logic   ptr_dec;

    rsc_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .pop_req(pop_req), .popr_req(popr_req),
        .start(start), .op_sel(op_sel), .op_q(op_q), .phase(phase),
        .done(done), .busy(busy)
    );

    // Pointer moves: pre-decrement on pop acceptance, post-increment at push end.
    always_comb begin
        ptr_dec = start && (op_sel != OP_PUSH);
        ptr_inc = (phase == PH_HI) && (op_q == OP_PUSH);
    end

    rsc_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .inc(ptr_inc), .dec(ptr_dec), .sp(sp)
    );

    rsc_addr #(
        .PC_W(PC_W), .ST_W(ST_W), .BYTE_W(BYTE_W),
        .ADDR_W(ADDR_W), .PTR_W(PTR_W), .BASE(BASE)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .start(start),
        .push_pc(push_pc), .push_stat(push_stat),
        .phase(phase), .op_q(op_q), .sp(sp),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_wdata(ram_wdata)
    );

    rsc_unpack #(.PC_W(PC_W), .ST_W(ST_W), .BYTE_W(BYTE_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .phase(phase), .op_q(op_q),
        .ram_rdata(ram_rdata), .pop_pc(pop_pc),
        .rest_stat(rest_stat), .rest_valid(rest_valid)
    );

    p_valid_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid |-> done);
    p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_sp_still_in_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ram_re) |=> $stable(sp));
endmodule

// File: tb/tb_ret_stack_ctrl.sv
// Bench for ret_stack_ctrl: a byte-array RAM model and a reference stack,
// with directed corners and a seeded random mix of requests.
module tb_ret_stack_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0, pop_req = 1'b0, popr_req = 1'b0;
    logic [11:0] push_pc = '0;
    logic [3:0]  push_stat = '0;
    logic        busy, done, rest_valid, ram_we, ram_re;
    logic [11:0] pop_pc;
    logic [3:0]  rest_stat;
    logic [2:0]  sp;
    logic [7:0]  ram_addr, ram_wdata, ram_rdata;

    logic [7:0]  mem [0:255];
    logic [11:0] m_pc [0:7];
    logic [3:0]  m_st [0:7];
    logic [2:0]  m_sp;
    logic [3:0]  m_rest;
    int          n_chk = 0, n_err = 0, cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ret_stack_ctrl dut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
        .popr_req(popr_req), .push_pc(push_pc), .push_stat(push_stat),
        .busy(busy), .done(done), .pop_pc(pop_pc), .rest_stat(rest_stat),
        .rest_valid(rest_valid), .sp(sp), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    assign ram_rdata = mem[ram_addr];
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

    function automatic logic [7:0] lo_byte(input logic [11:0] pc);
        return pc[7:0];
    endfunction
    function automatic logic [7:0] hi_byte(input logic [11:0] pc, input logic [3:0] st);
        return {st, pc[11:8]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // mask bit0 push, bit1 plain pop, bit2 restoring pop; disturb raises requests while busy
    task automatic run_op(input logic [2:0] mask, input logic [11:0] pc,
                          input logic [3:0] st, input bit disturb);
        int          kind;
        logic [2:0]  slot;
        logic [7:0]  base;
        kind = mask[0] ? 0 : (mask[2] ? 2 : 1);
        slot = (kind == 0) ? m_sp : m_sp - 3'd1;
        base = 8'd8 + {4'd0, slot, 1'b0};
        @(negedge clk);
        {popr_req, pop_req, push_req} = mask;
        push_pc = pc; push_stat = st;
        @(negedge clk);
        push_req = disturb; pop_req = disturb; popr_req = disturb;
        push_pc = ~pc; push_stat = ~st;
        chk(busy == 1'b1, "R6 busy first", busy, 1);
        chk(ram_addr == base, "R2/R4 first addr", ram_addr, base);
        if (kind == 0) begin
            chk(ram_we && !ram_re && ram_wdata == lo_byte(pc), "R2 low write",
                {ram_we, ram_re, ram_wdata}, {2'b10, lo_byte(pc)});
            chk(sp == m_sp, "R3 sp before end", sp, m_sp);
        end else begin
            chk(ram_re && !ram_we, "R4 read strobe", {ram_we, ram_re}, 2'b01);
            chk(sp == slot, "R4 sp pre-decrement", sp, slot);
        end
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0; popr_req = 1'b0;
        chk(busy == 1'b1, "R6 busy second", busy, 1);
        chk(ram_addr == base + 8'd1, "R2/R4 second addr", ram_addr, base + 8'd1);
        if (kind == 0)
            chk(ram_wdata == hi_byte(pc, st), "R2 high write", ram_wdata, hi_byte(pc, st));
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R6 done", {done, busy}, 2'b10);
        if (kind == 0) begin
            m_pc[slot] = pc; m_st[slot] = st; m_sp = m_sp + 3'd1;
            chk(sp == m_sp, "R3 sp after push", sp, m_sp);
            chk(mem[base] == lo_byte(pc) && mem[base + 8'd1] == hi_byte(pc, st),
                "R2 RAM bytes", {mem[base], mem[base + 8'd1]},
                {lo_byte(pc), hi_byte(pc, st)});
            chk(rest_valid == 1'b0, "R5 no valid on push", rest_valid, 0);
        end else begin
            m_sp = slot;
            chk(pop_pc == m_pc[slot], "R4 pop pc", pop_pc, m_pc[slot]);
            if (kind == 2) begin
                m_rest = m_st[slot];
                chk(rest_valid == 1'b1 && rest_stat == m_rest, "R5 restore",
                    {rest_valid, rest_stat}, {1'b1, m_rest});
            end else begin
                chk(rest_valid == 1'b0 && rest_stat == m_rest, "R5 plain keeps",
                    {rest_valid, rest_stat}, {1'b0, m_rest});
            end
            chk(sp == m_sp, "R4 sp after pop", sp, m_sp);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && rest_valid == 1'b0,
            "R6/R7 single pulse, nothing started", {done, busy, rest_valid}, 0);
        chk(sp == m_sp, "R7 sp untouched", sp, m_sp);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_err++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd7151));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) begin m_pc[i] = '0; m_st[i] = '0; end
        m_sp = '0; m_rest = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({sp, busy, done, rest_valid, ram_we, ram_re} == 0 && pop_pc == 0 && rest_stat == 0,
            "R1 reset", {sp, busy, done, rest_valid, ram_we, ram_re}, 0);
        // directed basic push / pops
        run_op(3'b001, 12'hABC, 4'h5, 1'b0);
        run_op(3'b001, 12'h123, 4'hE, 1'b0);
        run_op(3'b100, 12'h000, 4'h0, 1'b0);   // R5 restoring pop
        run_op(3'b010, 12'h000, 4'h0, 1'b0);   // R5 plain pop keeps nibble
        // R8 priority
        run_op(3'b111, 12'h7E1, 4'h9, 1'b0);
        run_op(3'b110, 12'h000, 4'h0, 1'b0);
        // R7 requests while busy
        run_op(3'b001, 12'hF0F, 4'h3, 1'b1);
        run_op(3'b010, 12'h000, 4'h0, 1'b1);
        // R9 wrap: nine pushes then pop past zero
        for (int i = 0; i < 9; i++) run_op(3'b001, 12'(i * 12'h111 + 1), 4'(i), 1'b0);
        for (int i = 0; i < 3; i++) run_op(3'b100, 12'h000, 4'h0, 1'b0);
        // R10 window holds through random traffic
        for (int i = 0; i < 300; i++) begin
            logic [2:0] m;
            m = 3'($urandom_range(1, 7));
            run_op(m, 12'($urandom), 4'($urandom), 1'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule